// File: doc/BRIEF.md
# Dual Fan Tachometer Period Counter

This block measures how fast two fans are spinning. For each fan it counts ticks of a slow reference clock during one tachometer period, from one rising tachometer edge to the next. The count is inversely proportional to fan speed, so a healthy fan gives a moderate number and a slow or stopped fan gives a large one. A programmable power-of-two prescaler sits in front of each counter. The 8-bit result saturates at 255, which marks a stopped or badly stalled fan.

A round-robin sequencer pulses `start_i` when the fan slot of its scan comes up. Fan 0 is measured first, and fan 1 is armed automatically when fan 0 completes. Each completed measurement pulses that fan's done bit for one cycle and updates its count and its error flag. The error flag is raised when the count is above the fan's limit, which is the largest acceptable count. Each tachometer input passes through a two-flop synchronizer and a three-sample majority filter before edge detection.

Top module: `fan_tach_meter`

## Requirements
- R1: The prescale code for fan 0 is `div_ctrl_i[5:4]` and for fan 1 is `div_ctrl_i[7:6]`. Code 0 divides the reference enable by 1, code 1 by 2, code 2 by 4 and code 3 by 8. Bits 3:0 of `div_ctrl_i` have no effect on any output.
- R2: When a fan's tachometer period spans M reference-enable pulses and its prescale factor is D, the stored count equals floor(M/D), as long as that value is below 255.
- R3: When the prescaled tick count reaches 255 before the closing edge arrives, the measurement ends at once with a count of 255 and a done pulse.
- R4: A fan that shows no rising edge after being armed completes with a count of 255 after 255 prescaled ticks, and still produces a done pulse.
- R5: On completion the fan's error flag is set exactly when the count is strictly greater than that fan's limit. A count equal to the limit is not an error. The flag holds until that fan's next completion.
- R6: `start_i` arms fan 0, and the done pulse of fan 0 arms fan 1. Each done bit is high for a single cycle, and the two done bits are never high together.
- R7: After reset, both counts are 0, both error flags are 0 and both done bits are 0.
- R8: A tachometer pulse that lasts a single clock cycle is rejected by the majority filter and does not open or close a measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_i | input | 2 | Raw tachometer levels, bit 0 = fan 0 |
| ref_en_i | input | 1 | One-cycle pulse per reference-oscillator period |
| div_ctrl_i | input | 8 | Control byte holding both prescale codes in bits 7:4 |
| start_i | input | 1 | Sequencer strobe that begins the fan measurement pair |
| limit_i | input | 16 | Largest acceptable count, fan 0 in bits 7:0 |
| count_o | output | 16 | Last completed counts, fan 0 in bits 7:0 |
| done_o | output | 2 | One-cycle completion pulse per fan |
| fan_err_o | output | 2 | Count-above-limit flag per fan |

## Verification
The bench sweeps all four prescale codes on both fans against tachometer periods that land below, near and above saturation. It includes a fan 1 period that saturates mid-count and a fan 0 input with no edges at all; a design that wrapped the counter instead of clamping it would report small counts for these slow fans. The limit is set alternately equal to the expected count and one below it, so an off-by-one compare (`>=` in place of `>`) would flip the flag. A run with injected one-cycle glitches catches a filter that let short spikes through, because such a filter would close the gate early and return a short count. Junk values in the unused control bits and timing checks on the two done pulses expose a swapped field or a broken hand-off from fan 0 to fan 1.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
    typedef enum logic [1:0] {
        GATE_IDLE  = 2'd0,
        GATE_ARM   = 2'd1,
        GATE_COUNT = 2'd2
    } gate_state_e;

    localparam int unsigned DIV_FIELD_W = 2;
    localparam int unsigned DIV_FIELD_LSB = 4;
endpackage

// File: rtl/tach_filter.sv
module tach_filter #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_i,
    output logic rise_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [1:0]             hist;
        logic                   level;
    } filt_s;

    filt_s q, d;
    logic  synced;
    logic  maj;

    always_comb begin
        d      = q;
        synced = q.sync[SYNC_STAGES-1];
        maj    = (synced & q.hist[0]) | (synced & q.hist[1]) | (q.hist[0] & q.hist[1]);
        d.sync = {q.sync[SYNC_STAGES-2:0], tach_i};
        d.hist = {q.hist[0], synced};
        d.level = maj;
        rise_o = maj & ~q.level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a detected edge is a single-cycle event
    a_r8_rise_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tach_channel.sv
module tach_channel
    import fan_tach_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             rise_i,
    input  logic             ref_en_i,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int unsigned PRE_W = (1 << DIV_W) - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        gate_state_e      st;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] count;
        logic             done;
        logic             err;
    } chan_s;

    chan_s q, d;
    logic [PRE_W-1:0] pre_lim;
    logic             tick;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        pre_lim = PRE_W'((32'd1 << div_sel_i) - 32'd1);
        tick    = ref_en_i && (q.pre == pre_lim);
        if (arm_i) begin
            d.st  = GATE_ARM;
            d.pre = '0;
            d.cnt = '0;
        end else begin
            case (q.st)
                GATE_ARM, GATE_COUNT: begin
                    if (rise_i && q.st == GATE_ARM) begin
                        d.st  = GATE_COUNT;
                        d.pre = '0;
                        d.cnt = '0;
                    end else if (rise_i) begin
                        d.st    = GATE_IDLE;
                        d.count = q.cnt;
                        d.done  = 1'b1;
                        d.err   = q.cnt > limit_i;
                    end else if (tick && q.cnt == CNT_MAX - 1'b1) begin
                        d.st    = GATE_IDLE;
                        d.cnt   = CNT_MAX;
                        d.count = CNT_MAX;
                        d.done  = 1'b1;
                        d.err   = CNT_MAX > limit_i;
                    end else if (tick) begin
                        d.pre = '0;
                        d.cnt = q.cnt + 1'b1;
                    end else if (ref_en_i) begin
                        d.pre = q.pre + 1'b1;
                    end
                end
                default: d.st = GATE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: GATE_IDLE, default: '0};
        else        q <= d;
    end

    assign count_o = q.count;
    assign done_o  = q.done;
    assign err_o   = q.err;

    // R3: the counter never sits at its ceiling while the gate is open
    a_r3_no_parked_max: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == GATE_COUNT) |-> (q.cnt != CNT_MAX));
    // R2: within one open gate the tick count only grows
    a_r2_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == GATE_COUNT && $past(q.st) == GATE_COUNT) |-> (q.cnt >= $past(q.cnt)));
    // R5: the flag matches the published count against the limit seen at completion
    a_r5_err_vs_limit: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_o == (count_o > $past(limit_i))));
    // R6: completion is a one-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
    import fan_tach_pkg::*;
#(
    parameter int unsigned NUM_FANS    = 2,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned CTRL_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_FANS-1:0]       tach_i,
    input  logic                      ref_en_i,
    input  logic [CTRL_W-1:0]         div_ctrl_i,
    input  logic                      start_i,
    input  logic [NUM_FANS*CNT_W-1:0] limit_i,
    output logic [NUM_FANS*CNT_W-1:0] count_o,
    output logic [NUM_FANS-1:0]       done_o,
    output logic [NUM_FANS-1:0]       fan_err_o
);
    localparam int unsigned DIV_W = DIV_FIELD_W;

    logic [NUM_FANS-1:0] rise;
    logic [NUM_FANS-1:0] arm;
    logic                ctrl_unused;

    assign ctrl_unused = ^div_ctrl_i[DIV_FIELD_LSB-1:0];

    for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
        if (g == 0) begin : g_first
            assign arm[g] = start_i;
        end else begin : g_chain
            assign arm[g] = done_o[g-1];
        end

        tach_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tach_i (tach_i[g]),
            .rise_o (rise[g])
        );

        tach_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm_i     (arm[g]),
            .rise_i    (rise[g]),
            .ref_en_i  (ref_en_i),
            .div_sel_i (div_ctrl_i[DIV_FIELD_LSB + g*DIV_W +: DIV_W]),
            .limit_i   (limit_i[g*CNT_W +: CNT_W]),
            .count_o   (count_o[g*CNT_W +: CNT_W]),
            .done_o    (done_o[g]),
            .err_o     (fan_err_o[g])
        );
    end

    // R6: the fans complete one at a time
    a_r6_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o));
endmodule

// File: tb/fan_tach_meter_bench.sv
`timescale 1ns/1ps
module fan_tach_meter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  tach_i;
    logic        ref_en_i;
    logic [7:0]  div_ctrl_i;
    logic        start_i;
    logic [15:0] limit_i;
    logic [15:0] count_o;
    logic [1:0]  done_o;
    logic [1:0]  fan_err_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    int  per0 = 10, per1 = 10;
    bit  stop0 = 0, glitch0 = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    fan_tach_meter u_fan_tach_meter (
        .clk(clk), .rst_n(rst_n), .tach_i(tach_i), .ref_en_i(ref_en_i),
        .div_ctrl_i(div_ctrl_i), .start_i(start_i), .limit_i(limit_i),
        .count_o(count_o), .done_o(done_o), .fan_err_o(fan_err_o)
    );

    function automatic logic tach_level(int c, int m, bit stopped, bit gl);
        int t  = 4 * m;
        int ph = (c + t - 2) % t;
        if (stopped) return 1'b0;
        if (gl && ph == 3 * m) return 1'b1;
        return ph < 2 * m;
    endfunction

    initial begin
        ref_en_i = 1'b0;
        tach_i   = 2'b00;
        forever begin
            @(negedge clk);
            cyc++;
            ref_en_i  = (cyc % 4 == 0);
            tach_i[0] = tach_level(cyc, per0, stop0, glitch0);
            tach_i[1] = tach_level(cyc, per1, 1'b0, 1'b0);
        end
    end

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_count(int m, int d, bit stopped);
        int v;
        if (stopped) return 255;
        v = m >> d;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic wait_done(int idx, output int when, output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_o[idx]) begin ok = 1; when = cyc; return; end
        end
    endtask

    task automatic run(int d0, int m0, int d1, int m1, bit lim_below, bit s0, bit gl, string tag);
        int e0, e1, l0, l1, t0, t1;
        bit ok0, ok1;
        e0 = expect_count(m0, d0, s0);
        e1 = expect_count(m1, d1, 1'b0);
        l0 = (lim_below && e0 > 0) ? e0 - 1 : e0;
        l1 = (lim_below && e1 > 0) ? e1 - 1 : e1;
        @(negedge clk);
        div_ctrl_i = {d1[1:0], d0[1:0], 4'(m0 + d1 * 3)};
        limit_i    = {l1[7:0], l0[7:0]};
        per0 = m0; per1 = m1; stop0 = s0; glitch0 = gl;
        repeat (12) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(0, t0, ok0);
        chk({"R6 fan0 done seen ", tag}, ok0, 1);
        if (!ok0) return;
        chk({"R6 single done ", tag}, done_o[1], 0);
        chk({"R1 R2 R3 R4 R8 fan0 count ", tag}, count_o[7:0], e0);
        chk({"R5 fan0 err ", tag}, fan_err_o[0], e0 > l0);
        wait_done(1, t1, ok1);
        chk({"R6 fan1 done seen ", tag}, ok1, 1);
        if (!ok1) return;
        chk({"R6 fan1 after fan0 ", tag}, t1 > t0, 1);
        chk({"R1 R2 R3 fan1 count ", tag}, count_o[15:8], e1);
        chk({"R5 fan1 err ", tag}, fan_err_o[1], e1 > l1);
        @(negedge clk);
        chk({"R6 done drops ", tag}, done_o, 0);
        chk({"R5 fan0 err held ", tag}, fan_err_o[0], e0 > l0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int ms[4] = '{5, 37, 130, 300};
        rst_n      = 1'b0;
        start_i    = 1'b0;
        div_ctrl_i = 8'h00;
        limit_i    = 16'h0000;
        repeat (6) @(negedge clk);
        chk("R7 reset count", count_o, 0);
        chk("R7 reset done", done_o, 0);
        chk("R7 reset err", fan_err_o, 0);
        rst_n = 1'b1;
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 4; p++) begin
                run(d, ms[p], 3 - d, ms[(p + 1) % 4], ((d + p) % 2) == 1, 1'b0, 1'b0,
                    $sformatf("d=%0d m=%0d", d, ms[p]));
            end
        end
        run(3, 40, 1, 60, 1'b0, 1'b1, 1'b0, "R4 stopped fan0");
        run(0, 37, 2, 100, 1'b1, 1'b0, 1'b1, "R8 glitch fan0");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule